// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Grant Parking

This block is a central arbiter for a shared bus with several masters. Each master has its own request line and its own grant line. At any time at most one grant is active, and a master drives the bus only while its grant is high. The arbiter also gives the current owner as a binary index with a valid flag.

The next owner is chosen continuously from the live requests while the current transaction runs. The grant register takes that choice at the edge where a transaction boundary is seen, so the new owner can start in the very next cycle. A boundary is a cycle with the bus not busy, or a cycle with the transaction-end pulse high. Fairness comes from a rotating priority pointer. The search starts one position after the master granted last and wraps around. When nobody is requesting at a boundary, the grant stays with the owner it already has (parking). If there has been no owner yet, the grant goes to master 0.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is held and after it is released, until the first boundary, `gntOut` is all zero, `ownerValid` is 0 and `ownerIdx` is 0.
- R2: At the first boundary with `reqIn` all zero and no owner yet, the grant parks on master 0: from the next cycle `gntOut` has only bit 0 set, `ownerIdx` is 0 and `ownerValid` is 1.
- R3: At a boundary with any request, the next owner is the first index with its request bit set, searching upward from the pointer and wrapping modulo NUM_MASTERS. Bit i of `reqIn` and `gntOut` belongs to master i.
- R4: The pointer is 0 after reset. Each grant to a requester sets it to (winner + 1) modulo NUM_MASTERS. A park on master 0 does not move it.
- R5: In a cycle with `busBusy`=1 and `txnEnd`=0, the grant does not change in the next cycle, whatever `reqIn` holds.
- R6: A boundary is `busBusy`=0 or `txnEnd`=1. The new grant appears in the cycle right after the boundary edge, with no idle arbitration cycle.
- R7: At a boundary with no request while an owner exists, the grant, `ownerIdx` and `ownerValid` stay unchanged (parking).
- R8: `gntOut` is always one-hot or zero. `ownerValid` equals the OR of `gntOut`, and when it is valid `gntOut[ownerIdx]` is 1.
- R9: When all masters request continuously at every boundary, they are granted in strictly rising cyclic order, so each waits fewer than NUM_MASTERS boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_MASTERS | Request line per master |
| busBusy | input | 1 | High while a transaction occupies the bus |
| txnEnd | input | 1 | Pulse in the last cycle of a transaction |
| gntOut | output | NUM_MASTERS | Grant line per master, one-hot or zero |
| ownerIdx | output | IDW | Binary index of the granted master |
| ownerValid | output | 1 | High once any master holds the grant |

## Verification
The bench goes through every pointer position against every nonzero request pattern. A design that searched from the winner itself instead of the next position would hand the bus straight back to the last owner and starve the others. The bench also checks a busy bus with no transaction-end pulse while requests change: a design that rearbitrated there would move the grant in the middle of a transaction. Idle boundaries are checked both before and after the first owner exists, which catches a missing park on master 0 and a grant that drops to zero when it should stay parked. A long pseudo-random phase then mixes busy, end pulses and requests against an arithmetic model.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic takeWinner;  // load grant from the round-robin winner
    logic parkHome;    // first park on master 0
  } arbStrobes_t;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int NUM_MASTERS = 4,
  localparam int IDW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic [NUM_MASTERS-1:0] reqVec,
  input  logic [IDW-1:0]         startPtr,
  output logic [IDW-1:0]         winIdx,
  output logic                   winFound
);
  // Search upward from startPtr, wrap modulo NUM_MASTERS
  always_comb begin
    winFound = 1'b0;
    winIdx   = '0;
    for (int k = 0; k < NUM_MASTERS; k++) begin
      int cand;
      cand = (int'(startPtr) + k) % NUM_MASTERS;
      if (!winFound && reqVec[cand]) begin
        winFound = 1'b1;
        winIdx   = IDW'(cand);
      end
    end
  end
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   busBusy,
  input  logic                   txnEnd,
  input  logic [NUM_MASTERS-1:0] reqVec,
  input  logic                   haveOwner,
  output arbStrobes_t            strobes
);
  logic atBoundary;
  logic anyReq;

  assign atBoundary = !busBusy || txnEnd;
  assign anyReq     = |reqVec;

  always_comb begin
    strobes            = '0;
    strobes.takeWinner = atBoundary && anyReq;
    strobes.parkHome   = atBoundary && !anyReq && !haveOwner;
  end

  // R8: control never asks for both actions at once
  always_comb begin
    strobe_excl_chk: assert (!(strobes.takeWinner && strobes.parkHome));
  end
endmodule

// File: rtl/arb_dpath.sv
module arb_dpath
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  localparam int IDW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  arbStrobes_t            strobes,
  input  logic [NUM_MASTERS-1:0] reqVec,
  output logic [NUM_MASTERS-1:0] gntVec,
  output logic [IDW-1:0]         ownerIdx,
  output logic                   ownerValid
);
  logic [IDW-1:0] rrPtr;
  logic [IDW-1:0] winIdx;
  logic           winFound;

  rr_pick #(.NUM_MASTERS(NUM_MASTERS)) i_pick (
    .reqVec  (reqVec),
    .startPtr(rrPtr),
    .winIdx  (winIdx),
    .winFound(winFound)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gntVec   <= '0;
      ownerIdx <= '0;
      rrPtr    <= '0;
    end else if (strobes.takeWinner) begin
      gntVec   <= NUM_MASTERS'(1) << winIdx;
      ownerIdx <= winIdx;
      rrPtr    <= (winIdx == IDW'(NUM_MASTERS - 1)) ? '0 : IDW'(winIdx + 1'b1);
    end else if (strobes.parkHome) begin
      gntVec   <= NUM_MASTERS'(1);
      ownerIdx <= '0;
    end
  end

  assign ownerValid = |gntVec;

  // R8
  onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gntVec));

  // R8
  owner_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    ownerValid |-> gntVec[ownerIdx]);

  // R3
  win_found_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeWinner |-> winFound);
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  localparam int IDW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] reqIn,
  input  logic                   busBusy,
  input  logic                   txnEnd,
  output logic [NUM_MASTERS-1:0] gntOut,
  output logic [IDW-1:0]         ownerIdx,
  output logic                   ownerValid
);
  arbStrobes_t strobes;

  arb_ctrl #(.NUM_MASTERS(NUM_MASTERS)) i_ctrl (
    .busBusy  (busBusy),
    .txnEnd   (txnEnd),
    .reqVec   (reqIn),
    .haveOwner(ownerValid),
    .strobes  (strobes)
  );

  arb_dpath #(.NUM_MASTERS(NUM_MASTERS)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqVec    (reqIn),
    .gntVec    (gntOut),
    .ownerIdx  (ownerIdx),
    .ownerValid(ownerValid)
  );

  // R5
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busBusy && !txnEnd) |=> $stable(gntOut));

  // R7
  park_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((!busBusy || txnEnd) && (reqIn == '0) && ownerValid) |=> $stable(gntOut));

  // R6
  grant_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((!busBusy || txnEnd) && (reqIn != '0)) |=> ((gntOut & $past(reqIn)) != '0));
endmodule

// File: tb/test_bus_arbiter.sv
module test_bus_arbiter;
  localparam int N = 4;
  localparam int IDW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] reqIn = '0;
  logic busBusy = 1'b1;
  logic txnEnd = 1'b0;
  logic [N-1:0] gntOut;
  logic [IDW-1:0] ownerIdx;
  logic ownerValid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state
  int  expIdx = 0;
  bit  expValid = 0;
  int  expPtr = 0;

  always #10 clk = ~clk;

  bus_arbiter #(.NUM_MASTERS(N)) i_bus_arbiter (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .busBusy(busBusy), .txnEnd(txnEnd),
    .gntOut(gntOut), .ownerIdx(ownerIdx), .ownerValid(ownerValid)
  );

  task automatic checkOut(string tag);
    logic [N-1:0] eg;
    eg = expValid ? (N'(1) << expIdx) : '0;
    total++;
    if (gntOut !== eg || ownerValid !== expValid || (expValid && ownerIdx !== IDW'(expIdx))
        || (!expValid && ownerIdx !== '0)) begin
      bad++;
      $display("FAIL %s: gnt=%b owner=%0d valid=%0d expected gnt=%b owner=%0d valid=%0d",
               tag, gntOut, ownerIdx, ownerValid, eg, expValid ? expIdx : 0, expValid);
    end
  endtask

  // one cycle: drive after negedge, update model, check at next negedge
  task automatic cyc(logic [N-1:0] r, logic busy, logic fin, string tag);
    reqIn = r; busBusy = busy; txnEnd = fin;
    if (!busy || fin) begin
      if (r != '0) begin
        for (int k = 0; k < N; k++) begin
          int c;
          c = (expPtr + k) % N;
          if (r[c]) begin
            expIdx = c; expValid = 1; expPtr = (c + 1) % N;
            break;
          end
        end
      end else if (!expValid) begin
        expValid = 1; expIdx = 0;
      end
    end
    @(negedge clk);
    checkOut(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    checkOut("R1 reset held");
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after release");
    // R5: busy without end, requests ignored
    cyc(4'b1010, 1'b1, 1'b0, "R5 busy no end");
    cyc(4'b0110, 1'b1, 1'b0, "R5 busy no end");
    // R2: first idle boundary parks on 0
    cyc(4'b0000, 1'b0, 1'b0, "R2 park home");
    // R7: stays parked
    cyc(4'b0000, 1'b0, 1'b0, "R7 park hold");
    // R6: end pulse hands over in one cycle
    cyc(4'b0100, 1'b1, 1'b1, "R6 handover on end");
    cyc(4'b0000, 1'b1, 1'b1, "R7 park on owner 2");
    cyc(4'b1001, 1'b1, 1'b0, "R5 hold mid transfer");
    cyc(4'b1001, 1'b1, 1'b1, "R4 ptr after 2 picks 3");
    // R9: all request, rotating order
    for (int i = 0; i < 2 * N; i++) cyc(4'b1111, 1'b1, 1'b1, "R9 rotation");
    // R3/R4: exhaustive pointer x pattern sweep
    for (int p = 0; p < N; p++) begin
      for (int pat = 1; pat < (1 << N); pat++) begin
        cyc(N'(1) << ((p + N - 1) % N), 1'b0, 1'b0, "R4 set pointer");
        cyc(N'(pat), 1'b1, 1'b1, "R3 sweep pick");
        cyc(N'(pat), 1'b1, 1'b0, "R5 sweep hold");
        cyc(4'b0000, 1'b0, 1'b0, "R7 sweep park");
      end
    end
    // mixed pseudo-random phase
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[3:0] & {4{lfsr[9]}}, lfsr[5] | lfsr[6], lfsr[7] & lfsr[8], "R3 R8 mixed");
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule